// File: doc/BRIEF.md
# Receive FIFO with Trigger Interrupt

This block buffers characters that arrive from the receive side of a memory-mapped serial port until software reads them. The receiver offers one character per cycle on a push interface: an 8-bit data byte, a 4-bit error tag and a valid strobe. Each stored entry is 12 bits, with the tag in the upper four bits and the byte in the lower eight. A data-register read presents the head entry on `popData` and pulses `popReq` to remove it.

A mode input selects the storage depth. When it is high, the buffer holds 16 entries. When it is low, only one holding slot is used. Storage is a circular buffer with a read pointer and an occupancy count, and both wrap modulo the depth parameter.

The block drives registered empty and full flags, a `canAccept` signal that tells the receiver whether there is room, and a receive-interrupt level. The interrupt rises on the push that brings the occupancy up to the trigger level. It falls on the pop that brings the occupancy down to one less than the trigger level. The trigger level is a parameter with a default of 1, so by default the interrupt is high exactly when the buffer is not empty.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, emptyFlag=1, fullFlag=0, rxIrq=0 and canAccept=1.
- R2: Entries leave in arrival order. popData always shows the head entry as {tag[3:0], data[7:0]}. A pop with at least one entry stored advances the head to the next entry.
- R3: A push whose tag bit 2 is set marks a line break, and bit 10 of the stored entry is set. Its stored data byte is zero whatever pushData carried, so a break with no other tag bits reads back as 0x400.
- R4: With fifoEn=1 the buffer holds 16 entries. fullFlag rises on the push that makes the count 16. canAccept is low while the count is 16 and high otherwise.
- R5: With fifoEn=0 the buffer holds one entry. fullFlag rises after any accepted push, and canAccept is low while that entry is held.
- R6: A push arriving while canAccept is low is dropped. The count, the stored contents and the order are unchanged.
- R7: An accepted push clears emptyFlag. A pop that leaves zero entries sets emptyFlag.
- R8: Any pop clears fullFlag.
- R9: rxIrq sets on the push that makes the count equal to the trigger level (1). It clears on the pop that makes the count equal to the trigger level minus one (0).
- R10: A pop from an empty buffer changes neither the read pointer nor the count. popData keeps showing the slot at the read pointer, and the next push lands in that slot.
- R11: The read and write positions wrap from the last slot to slot 0 without losing order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | 1 selects 16-entry depth, 0 selects single holding slot |
| pushValid | input | 1 | Receiver offers a character this cycle |
| pushData | input | 8 | Received data byte |
| pushTag | input | 4 | Error tag bits; bit 2 marks a line break |
| popReq | input | 1 | Data-register read removes the head entry |
| popData | output | 12 | Head entry {tag, data} |
| emptyFlag | output | 1 | No entries stored |
| fullFlag | output | 1 | Buffer full for the current depth |
| canAccept | output | 1 | Count below the current depth |
| rxIrq | output | 1 | Receive-interrupt request level |

## Verification
The bench fills the 16-entry buffer starting from a non-zero read pointer. This makes the write side wrap past slot 15 and checks that order survives the wrap. A design with a bad wrap would return stale or out-of-order bytes. It then pushes a seventeenth character into the full buffer and drains it. A design that overwrote the head or grew the count would show a wrong head or stay non-empty after sixteen pops. In single-slot mode it checks that full appears after the first push and that a second push is rejected. It also pops an empty buffer and then pushes, checking that the new character appears at the head. A design that moved the pointer on an empty pop would show the wrong slot. Break entries are pushed with a non-zero data byte, which exposes a design that stores the byte instead of clearing it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int RXQ_DEPTH     = 16;
  localparam int RXQ_DATA_W    = 8;
  localparam int RXQ_TAG_W     = 4;
  localparam int RXQ_BREAK_BIT = 2;
  localparam int RXQ_TRIGGER   = 1;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic wrEn;   // store the incoming entry at the write slot
    logic rdAdv;  // advance the head past the current entry
  } rxqStrobe_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH      = RXQ_DEPTH,
  parameter int TRIG_LEVEL = RXQ_TRIGGER
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  logic       pushValid,
  input  logic       popReq,
  output rxqStrobe_t strobe,
  output logic       emptyFlag,
  output logic       fullFlag,
  output logic       canAccept,
  output logic       rxIrq
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIG_C  = CNT_W'(TRIG_LEVEL);
  localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIG_LEVEL - 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] curDepth;
  logic             pushOk;
  logic             popOk;

  always_comb begin
    curDepth  = fifoEn ? DEPTH_C : CNT_W'(1);
    canAccept = (count < curDepth);
    pushOk    = pushValid && canAccept;
    popOk     = popReq && (count != '0);
    nextCount = count + CNT_W'(pushOk) - CNT_W'(popOk);
    strobe.wrEn  = pushOk;
    strobe.rdAdv = popOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      emptyFlag <= 1'b1;
      fullFlag  <= 1'b0;
      rxIrq     <= 1'b0;
    end else begin
      count <= nextCount;

      if (pushOk || popOk)
        emptyFlag <= (nextCount == '0);

      if (pushOk && (!fifoEn || nextCount == DEPTH_C))
        fullFlag <= 1'b1;
      else if (popReq)
        fullFlag <= 1'b0;

      if (pushOk && !popOk && nextCount == TRIG_C)
        rxIrq <= 1'b1;
      else if (popOk && !pushOk && nextCount == TRIG_M1)
        rxIrq <= 1'b0;
    end
  end

  // R4: occupancy never exceeds the storage depth
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  // R7: empty flag tracks a zero occupancy
  p_empty_tracks_r7: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag == (count == '0));

  // R6: a refused push leaves the occupancy alone
  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !canAccept && !popReq) |=> $stable(count));

  // R5: single-slot mode reports full after an accepted push
  p_single_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && pushValid && canAccept) |=> fullFlag);

  // R8: a pop without a push leaves full low
  p_pop_clears_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushValid) |=> !fullFlag);

  // R9: the interrupt rises only at the trigger occupancy
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> (count == TRIG_C));

endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH     = RXQ_DEPTH,
  parameter int DATA_W    = RXQ_DATA_W,
  parameter int TAG_W     = RXQ_TAG_W,
  parameter int BREAK_BIT = RXQ_BREAK_BIT
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rxqStrobe_t              strobe,
  input  logic [DATA_W-1:0]       pushData,
  input  logic [TAG_W-1:0]        pushTag,
  output logic [DATA_W+TAG_W-1:0] popData
);

  localparam int ENT_W = DATA_W + TAG_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_C = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_C) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0]            rdPtr;
  logic [PTR_W-1:0]            wrPtr;
  logic [ENT_W-1:0]            wrEntry;
  logic                        isBreak;
  logic [DEPTH-1:0][ENT_W-1:0] slotArr;

  always_comb begin
    isBreak = pushTag[BREAK_BIT];
    wrEntry = {pushTag, (isBreak ? {DATA_W{1'b0}} : pushData)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (strobe.rdAdv) rdPtr <= stepPtr(rdPtr);
      if (strobe.wrEn)  wrPtr <= stepPtr(wrPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (strobe.wrEn && wrPtr == PTR_W'(i))
        q <= wrEntry;
    end
    assign slotArr[i] = q;
  end

  assign popData = slotArr[rdPtr];

  // R11: the head steps by one slot with wrap on each pop
  p_rd_wrap_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAdv |=> (rdPtr == stepPtr($past(rdPtr))));

  // R10: without a real pop the head position holds
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdAdv |=> $stable(rdPtr));

  // R3: a stored break carries a zero data byte
  p_break_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && pushTag[BREAK_BIT]) |=>
      (slotArr[$past(wrPtr)][DATA_W-1:0] == '0));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH      = RXQ_DEPTH,
  parameter int DATA_W     = RXQ_DATA_W,
  parameter int TAG_W      = RXQ_TAG_W,
  parameter int BREAK_BIT  = RXQ_BREAK_BIT,
  parameter int TRIG_LEVEL = RXQ_TRIGGER
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fifoEn,
  input  logic                    pushValid,
  input  logic [DATA_W-1:0]       pushData,
  input  logic [TAG_W-1:0]        pushTag,
  input  logic                    popReq,
  output logic [DATA_W+TAG_W-1:0] popData,
  output logic                    emptyFlag,
  output logic                    fullFlag,
  output logic                    canAccept,
  output logic                    rxIrq
);

  rxqStrobe_t strobe;

  rxq_ctrl #(
    .DEPTH      (DEPTH),
    .TRIG_LEVEL (TRIG_LEVEL)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fifoEn    (fifoEn),
    .pushValid (pushValid),
    .popReq    (popReq),
    .strobe    (strobe),
    .emptyFlag (emptyFlag),
    .fullFlag  (fullFlag),
    .canAccept (canAccept),
    .rxIrq     (rxIrq)
  );

  rxq_store #(
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .TAG_W     (TAG_W),
    .BREAK_BIT (BREAK_BIT)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushData (pushData),
    .pushTag  (pushTag),
    .popData  (popData)
  );

endmodule

// File: tb/rxq_fifo_test.sv
module rxq_fifo_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoEn = 1'b1;
  logic        pushValid = 1'b0;
  logic [7:0]  pushData = '0;
  logic [3:0]  pushTag = '0;
  logic        popReq = 1'b0;
  logic [11:0] popData;
  logic        emptyFlag, fullFlag, canAccept, rxIrq;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  rxq_fifo uut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .pushValid(pushValid),
    .pushData(pushData), .pushTag(pushTag), .popReq(popReq),
    .popData(popData), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .canAccept(canAccept), .rxIrq(rxIrq)
  );

  // vector: op(2) 1=push 2=pop, data(8), tag(4), chkHead(1), head(12), empty, full, irq
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 8'h41, 4'h0, 1'b1, 12'h041, 1'b0, 1'b0, 1'b1},
    {2'd1, 8'h42, 4'h1, 1'b1, 12'h041, 1'b0, 1'b0, 1'b1},
    {2'd1, 8'h55, 4'h4, 1'b1, 12'h041, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h00, 4'h0, 1'b1, 12'h142, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h00, 4'h0, 1'b1, 12'h400, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h00, 4'h0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h7E, 4'hB, 1'b1, 12'hB7E, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h00, 4'h0, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doPush(input logic [7:0] d, input logic [3:0] t);
    pushValid = 1'b1; pushData = d; pushTag = t;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic doPop();
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 empty", emptyFlag, 1);
    chk("R1 full", fullFlag, 0);
    chk("R1 irq", rxIrq, 0);
    chk("R1 canAccept", canAccept, 1);

    // vector walk: R2 order/format, R3 break, R7 empty, R9 irq
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][29:28] == 2'd1) doPush(VEC[i][27:20], VEC[i][19:16]);
      else doPop();
      if (VEC[i][15]) chk($sformatf("R2/R3 head v%0d", i), popData, VEC[i][14:3]);
      chk($sformatf("R7 empty v%0d", i), emptyFlag, VEC[i][2]);
      chk($sformatf("R4 full v%0d", i), fullFlag, VEC[i][1]);
      chk($sformatf("R9 irq v%0d", i), rxIrq, VEC[i][0]);
    end

    // R4 / R11: fill 16 starting at slot 4 so the write side wraps
    for (int i = 0; i < 16; i++) begin
      doPush(8'(8'h10 + i), 4'h0);
      if (i == 14) begin
        chk("R4 not full at 15", fullFlag, 0);
        chk("R4 canAccept at 15", canAccept, 1);
      end
    end
    chk("R4 full at 16", fullFlag, 1);
    chk("R4 canAccept at 16", canAccept, 0);
    chk("R9 irq held while full", rxIrq, 1);

    // R6: push into a full buffer is dropped
    doPush(8'hEE, 4'h0);
    chk("R6 head after drop", popData, 12'h010);
    chk("R6 still full", fullFlag, 1);

    // drain: R11 order across wrap, R8 full clears on pop
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R11 order %0d", i), popData, 12'(8'h10 + i));
      doPop();
      if (i == 0) chk("R8 full cleared", fullFlag, 0);
      if (i == 14) chk("R9 irq before last pop", rxIrq, 1);
    end
    chk("R6 empty after 16 pops", emptyFlag, 1);
    chk("R9 irq cleared at zero", rxIrq, 0);

    // R5 single-slot mode
    fifoEn = 1'b0;
    @(negedge clk);
    chk("R5 canAccept empty", canAccept, 1);
    doPush(8'h11, 4'h0);
    chk("R5 full after push", fullFlag, 1);
    chk("R5 canAccept held", canAccept, 0);
    chk("R9 irq single", rxIrq, 1);
    doPush(8'h22, 4'h0);
    chk("R6 single drop head", popData, 12'h011);
    doPop();
    chk("R5 empty after pop", emptyFlag, 1);
    chk("R8 full after pop", fullFlag, 0);
    doPush(8'h5A, 4'h0);
    chk("R6 single second entry", popData, 12'h05A);
    doPop();

    // R10: pop from empty holds pointer and count
    held = popData;
    doPop();
    chk("R10 head stable", popData, held);
    chk("R10 still empty", emptyFlag, 1);
    doPush(8'h33, 4'h0);
    chk("R10 next push at head", popData, 12'h033);
    chk("R7 empty cleared", emptyFlag, 0);

    // R3 break with other tag bits
    doPop();
    doPush(8'hFF, 4'h6);
    chk("R3 break with tag", popData, 12'h600);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule